// File: doc/BRIEF.md
# Diagnostic Output Selector with Divider Bypass

This block produces the diagnostic output of a clock synthesizer and the bypass path of its dividers. A 3-bit select picks which internal node is shown on the diagnostic output. The choices are the configuration shift register's serial output, a fixed high, a fixed low, the reference clock divided by 16, the feedback divide-by-M counter, the main output, the main output divided by 4, and a bypass mode.

In bypass mode the serial configuration clock replaces the synthesized clock. It drives both the M counter and the post divider directly. The post divider then feeds the main output, and the M counter feeds the diagnostic output. This allows slow, fully controlled clocking for board-level debug.

All clocks are modelled as single-cycle enable ticks sampled on one system clock, so the block is ordinary synchronous logic. Changing the select or the post-divide code clears the affected counters in the same cycle, so a new setting always starts from a clean period.

Top module: `clkdiag_sel`

## Requirements
- R1: With `tsel` = 3'b000, `test_out` equals the value `shreg_bit` had at the previous rising edge of `clk`.
- R2: With `tsel` = 3'b001, `test_out` is held at 1. With `tsel` = 3'b101, it is held at 0. In both cases it makes no transitions.
- R3: With `tsel` = 3'b010, `test_out` is a square wave with a period of 16 `ref_tick` pulses.
- R4: With `tsel` = 3'b011, `test_out` carries the M counter output. This is a one-cycle pulse once every `mval` feed ticks (an `mval` of 0 or 1 counts as 1). It is never high in a cycle that did not follow a feed tick.
- R5: With `tsel` = 3'b100, `test_out` follows `main_out`, delayed by one cycle.
- R6: With `tsel` = 3'b111, `test_out` toggles on every second rising edge of `main_out`, which divides the main output by 4.
- R7: With `tsel` = 3'b110, `sclk_tick` replaces `vco_tick` as the feed for both the M counter and the post divider. `test_out` carries the M counter output and `main_out` carries the post divider output.
- R8: `ncode` selects the post-divide ratio: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 1. An even ratio R gives a 50% square wave that toggles every R/2 feed ticks. A ratio of 1 drives `main_out` high for exactly the cycle after each feed tick.
- R9: A change of `tsel` or `ncode` clears the M counter, the post divider and the divide-by-4 stage at the next clock edge, so `main_out` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vco_tick | input | 1 | Synthesized clock enable (normal feed) |
| ref_tick | input | 1 | Reference clock enable |
| sclk_tick | input | 1 | Serial configuration clock enable (bypass feed) |
| shreg_bit | input | 1 | Serial output of the configuration shift register |
| tsel | input | 3 | Diagnostic source select |
| mval | input | 9 | M divide value |
| ncode | input | 2 | Post-divide code |
| main_out | output | 1 | Main clock output |
| test_out | output | 1 | Diagnostic output |

## Verification
`main_out` is registered once after the feed tick. `test_out` adds one more register, so the shift-register and main-output paths appear one cycle after their source. The bench checks these paths cycle by cycle, driving on the falling edge and sampling on the next falling edge.

The divided sources are checked by counting rising edges over a 960-cycle window. The window opens at least 40 cycles after any change of setting, and each count may differ by one from the ideal because of window phase. The clear on a setting change is checked on the first falling edge after the changing clock edge.

// File: rtl/clkdiag_pkg.sv
package clkdiag_pkg;

   typedef enum logic [2:0] {
      SRC_SHREG  = 3'b000,
      SRC_ONE    = 3'b001,
      SRC_REF16  = 3'b010,
      SRC_MCNT   = 3'b011,
      SRC_MAIN   = 3'b100,
      SRC_ZERO   = 3'b101,
      SRC_BYPASS = 3'b110,
      SRC_MAIN4  = 3'b111
   } src_sel_e;

   // post-divide ratio from the 2-bit code (order is behavioural)
   function automatic int unsigned post_ratio(input logic [1:0] code);
      case (code)
         2'b00:   return 2;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/clkdiag_tdiv.sv
module clkdiag_tdiv #(
   parameter int unsigned HALF = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic q
);
   localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

   if (HALF < 1) begin : g_bad
      $error("clkdiag_tdiv: HALF must be at least 1");
   end

   if (HALF == 1) begin : g_toggle
      always_ff @(posedge clk) begin
         if (!rst_n || clr) q <= 1'b0;
         else if (tick)     q <= ~q;
      end
   end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            cnt <= '0;
            q   <= 1'b0;
         end else if (tick) begin
            if (cnt == CW'(HALF - 1)) begin
               cnt <= '0;
               q   <= ~q;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   AST_TDIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(q)); // R3
endmodule

// File: rtl/clkdiag_mcnt.sv
module clkdiag_mcnt #(
   parameter int unsigned MW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [MW-1:0] mval,
   output logic          pulse
);
   if (MW < 2) begin : g_bad
      $error("clkdiag_mcnt: MW must be at least 2");
   end

   logic [MW-1:0] cnt;
   logic [MW-1:0] meff;
   logic          term;

   always_comb begin
      meff = (mval <= MW'(1)) ? MW'(1) : mval;
      term = (cnt >= meff - MW'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else if (tick) begin
         pulse <= term;
         cnt   <= term ? '0 : cnt + 1'b1;
      end else begin
         pulse <= 1'b0;
      end
   end

   AST_MPULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(tick)); // R4
endmodule

// File: rtl/clkdiag_ndiv.sv
module clkdiag_ndiv
   import clkdiag_pkg::*;
#(
   parameter int unsigned NW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [NW-1:0] code,
   output logic          q
);
   if (NW != 2) begin : g_bad
      $error("clkdiag_ndiv: NW must be 2");
   end

   logic [2:0] cnt;
   logic [2:0] half_m1;
   logic       pass;

   always_comb begin
      pass    = (post_ratio(code) == 1);
      half_m1 = 3'(post_ratio(code) / 2 - 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
         q   <= 1'b0;
      end else if (pass) begin
         cnt <= '0;
         q   <= tick;
      end else if (tick) begin
         if (cnt >= half_m1) begin
            cnt <= '0;
            q   <= ~q;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_PASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pass && !clr && !tick) |=> !q); // R8
   AST_EVEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass && !clr && !tick) |=> $stable(q)); // R8
endmodule

// File: rtl/clkdiag_sel.sv
module clkdiag_sel
   import clkdiag_pkg::*;
#(
   parameter int unsigned MW       = 9,
   parameter int unsigned NW       = 2,
   parameter int unsigned TW       = 3,
   parameter int unsigned REF_DIV  = 16,
   parameter int unsigned POST_DIV = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vco_tick,
   input  logic          ref_tick,
   input  logic          sclk_tick,
   input  logic          shreg_bit,
   input  logic [TW-1:0] tsel,
   input  logic [MW-1:0] mval,
   input  logic [NW-1:0] ncode,
   output logic          main_out,
   output logic          test_out
);
   localparam int unsigned REF_HALF  = REF_DIV / 2;
   localparam int unsigned POST_HALF = POST_DIV / 2;

   if (TW != 3) begin : g_bad_tw
      $error("clkdiag_sel: TW must be 3");
   end
   if (REF_DIV < 2 || (REF_DIV % 2) != 0) begin : g_bad_ref
      $error("clkdiag_sel: REF_DIV must be even and at least 2");
   end
   if (POST_DIV < 2 || (POST_DIV % 2) != 0) begin : g_bad_post
      $error("clkdiag_sel: POST_DIV must be even and at least 2");
   end

   logic [TW-1:0] sel_q;
   logic [NW-1:0] ncode_q;
   logic          sel_chg, n_chg, clr_div;
   logic          bypass, feed;
   logic          m_pulse, ndiv_q, main_prev, main_rise;
   logic          ref_q, post_q;
   src_sel_e      src;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q   <= '0;
         ncode_q <= '0;
      end else begin
         sel_q   <= tsel;
         ncode_q <= ncode;
      end
   end

   always_comb begin
      src       = src_sel_e'(tsel);
      sel_chg   = (tsel != sel_q);
      n_chg     = (ncode != ncode_q);
      clr_div   = sel_chg || n_chg;
      bypass    = (src == SRC_BYPASS);
      feed      = bypass ? sclk_tick : vco_tick;
      main_rise = ndiv_q && !main_prev;
   end

   clkdiag_mcnt #(.MW(MW)) u_mcnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_div), .tick(feed),
      .mval(mval), .pulse(m_pulse)
   );

   clkdiag_ndiv #(.NW(NW)) u_ndiv (
      .clk(clk), .rst_n(rst_n), .clr(clr_div), .tick(feed),
      .code(ncode), .q(ndiv_q)
   );

   clkdiag_tdiv #(.HALF(REF_HALF)) u_ref (
      .clk(clk), .rst_n(rst_n), .clr(sel_chg), .tick(ref_tick), .q(ref_q)
   );

   clkdiag_tdiv #(.HALF(POST_HALF)) u_post (
      .clk(clk), .rst_n(rst_n), .clr(clr_div), .tick(main_rise), .q(post_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || clr_div) main_prev <= 1'b0;
      else                   main_prev <= ndiv_q;
   end

   assign main_out = ndiv_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         test_out <= 1'b0;
      end else begin
         unique case (src)
            SRC_SHREG:  test_out <= shreg_bit;
            SRC_ONE:    test_out <= 1'b1;
            SRC_REF16:  test_out <= ref_q;
            SRC_MCNT:   test_out <= m_pulse;
            SRC_MAIN:   test_out <= ndiv_q;
            SRC_ZERO:   test_out <= 1'b0;
            SRC_BYPASS: test_out <= m_pulse;
            SRC_MAIN4:  test_out <= post_q;
            default:    test_out <= 1'b0;
         endcase
      end
   end

   AST_SHREG_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (tsel == 3'b000) |=> (test_out == $past(shreg_bit))); // R1
   AST_CONST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tsel == 3'b001) |=> test_out); // R2
   AST_CONST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tsel == 3'b101) |=> !test_out); // R2
   AST_MAIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tsel == 3'b100) |=> (test_out == $past(main_out))); // R5
   AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ncode != ncode_q) |=> !main_out); // R9
   AST_BYPASS_IGNORES_VCO: assert property (@(posedge clk) disable iff (!rst_n)
      (tsel == 3'b110 && !sclk_tick && tsel == sel_q && ncode == ncode_q && ncode != 2'b11)
      |=> $stable(main_out)); // R7
endmodule

// File: tb/clkdiag_sel_test.sv
module clkdiag_sel_test;
   localparam int CLK_PERIOD = 10;
   localparam int WIN        = 960;
   localparam int SETTLE     = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vco_tick = 1'b0, ref_tick = 1'b0, sclk_tick = 1'b0;
   logic       shreg_bit = 1'b0;
   logic [2:0] tsel = 3'b000;
   logic [8:0] mval = 9'd5;
   logic [1:0] ncode = 2'b00;
   logic       main_out, test_out;

   int n_checks = 0, n_fail = 0;
   int vco_per = 2, ref_per = 3, sclk_per = 5;
   int vc = 0, rc = 0, sc = 0;
   bit done = 0;

   clkdiag_sel uut (
      .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
      .sclk_tick(sclk_tick), .shreg_bit(shreg_bit), .tsel(tsel), .mval(mval),
      .ncode(ncode), .main_out(main_out), .test_out(test_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(negedge clk) begin
      vc = (vc + 1) % vco_per;  vco_tick  <= (vc == 0);
      rc = (rc + 1) % ref_per;  ref_tick  <= (rc == 0);
      sc = (sc + 1) % sclk_per; sclk_tick <= (sc == 0);
   end

   function automatic int ratio_of(input logic [1:0] c);
      case (c)
         2'b00: return 2;
         2'b01: return 4;
         2'b10: return 8;
         default: return 1;
      endcase
   endfunction

   task automatic check_eq(input string req, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic check_near(input string req, input int got, input int exp);
      n_checks++;
      if (got > exp + 1 || got < exp - 1) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d (+/-1)", req, got, exp);
      end
   endtask

   // rising edges of main_out and test_out over WIN cycles
   task automatic measure(output int me, output int te);
      logic pm, pt;
      me = 0; te = 0;
      @(negedge clk);
      pm = main_out; pt = test_out;
      repeat (WIN) begin
         @(negedge clk);
         if (main_out && !pm) me++;
         if (test_out && !pt) te++;
         pm = main_out; pt = test_out;
      end
   endtask

   task automatic setup(input logic [2:0] s, input logic [1:0] n, input logic [8:0] m);
      @(negedge clk);
      tsel = s; ncode = n; mval = m;
      repeat (SETTLE) @(negedge clk);
   endtask

   initial begin
      int me, te, mm;
      logic [1:0] nn;
      logic b;
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      check_eq("reset main_out", int'(main_out), 0);
      check_eq("reset test_out", int'(test_out), 0);
      rst_n = 1'b1;

      // R1: shift-register path, one cycle lag
      setup(3'b000, 2'b00, 9'd5);
      for (int i = 0; i < 16; i++) begin
         b = 1'($urandom);
         shreg_bit = b;
         @(negedge clk);
         check_eq("R1 shreg follow", int'(test_out), int'(b));
      end

      // R2: constants
      setup(3'b001, 2'b00, 9'd5);
      check_eq("R2 const one level", int'(test_out), 1);
      measure(me, te);
      check_eq("R2 const one edges", te, 0);
      setup(3'b101, 2'b00, 9'd5);
      check_eq("R2 const zero level", int'(test_out), 0);
      measure(me, te);
      check_eq("R2 const zero edges", te, 0);

      // R3: reference /16
      setup(3'b010, 2'b00, 9'd5);
      measure(me, te);
      check_near("R3 ref div16", te, WIN / (ref_per * 16));

      // R4: M counter, directed and random M
      setup(3'b011, 2'b00, 9'd5);
      measure(me, te);
      check_near("R4 mcnt M=5", te, WIN / (vco_per * 5));
      setup(3'b011, 2'b00, 9'd0);
      measure(me, te);
      check_near("R4 mcnt M=0 as 1", te, WIN / vco_per);
      for (int i = 0; i < 4; i++) begin
         mm = 2 + int'($urandom % 19);
         setup(3'b011, 2'(($urandom) % 4), 9'(mm));
         measure(me, te);
         check_near("R4 mcnt random M", te, WIN / (vco_per * mm));
      end

      // R8 / R5: every post-divide code, main shown on test
      for (int c = 0; c < 4; c++) begin
         setup(3'b100, 2'(c), 9'd5);
         measure(me, te);
         check_near("R8 post ratio", me, WIN / (vco_per * ratio_of(2'(c))));
         check_eq("R5 test follows main", te, me);
      end
      for (int i = 0; i < 3; i++) begin
         nn = 2'($urandom % 4);
         setup(3'b100, nn, 9'd5);
         measure(me, te);
         check_near("R8 post ratio random", me, WIN / (vco_per * ratio_of(nn)));
      end

      // R6: main /4
      setup(3'b111, 2'b00, 9'd5);
      measure(me, te);
      check_near("R6 main div4", te, WIN / (vco_per * 2 * 4));

      // R7: bypass, feed from serial clock
      setup(3'b110, 2'b00, 9'd3);
      measure(me, te);
      check_near("R7 bypass main", me, WIN / (sclk_per * 2));
      check_near("R7 bypass mcnt", te, WIN / (sclk_per * 3));

      // R9: change of ncode clears the post divider
      setup(3'b100, 2'b10, 9'd5);
      for (int i = 0; i < 40 && !main_out; i++) @(negedge clk);
      check_eq("R9 main high before change", int'(main_out), 1);
      ncode = 2'b01;
      @(negedge clk);
      check_eq("R9 cleared after ncode change", int'(main_out), 0);
      setup(3'b100, 2'b10, 9'd5);
      for (int i = 0; i < 40 && !main_out; i++) @(negedge clk);
      tsel = 3'b111;
      @(negedge clk);
      check_eq("R9 cleared after tsel change", int'(main_out), 0);

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule